// File: doc/BRIEF.md
# Slave Audio Word Receiver with Frame-Sync Error Handling

This block receives two-channel serial audio as a slave. An external master drives the bit clock, the word-select line and the serial data line. The block samples all three on the rising edge of the bit clock. Every change in the level of word select marks the start of a frame half. After a programmable delay of zero, one or two bit clocks, the block shifts in a 16-bit word, most significant bit first. It then presents the word on a parallel output with a channel tag and a one-cycle valid strobe.

Under the usual framing, a word-select edge arrives every 16 bit clocks. An edge that arrives sooner is early. A control input selects one of two responses to an early edge. The block can ignore the edge and finish the word already in progress. Otherwise it discards the partial word, raises a sticky sync-error flag and starts a new word aligned to the early edge. The flag stays set until a clear input is seen at a rising bit-clock edge.

Top module: `i2s_fsync_rx`

## Requirements
- R1: After reset, `valid` is 0, `word_out` is 0 and `sync_err` is 0.
- R2: A frame edge is a change in the sampled level of `ws` between two consecutive rising `bclk` edges. A `ws` level held for any number of bit clocks starts no further words.
- R3: If an edge is detected at rising edge t and `delay` is D (0, 1 or 2), the MSB of the word is the `sd` value sampled at rising edge t+D. The next 15 samples follow in order, MSB first.
- R4: A word started by a falling `ws` edge carries `chan_out` = 0 (left). A word started by a rising edge carries `chan_out` = 1 (right).
- R5: `valid` is high for exactly one bit clock, starting at the rising edge after the LSB is sampled. In that cycle `word_out` and `chan_out` hold the completed word and its tag. Each completed word produces exactly one strobe, in arrival order.
- R6: An edge is early if it arrives fewer than 16 bit clocks after the last accepted edge. The first edge after reset is never early.
- R7: With `fs_ignore` = 1, an early edge has no effect. The word in progress completes with its original alignment and channel, and `sync_err` does not change.
- R8: With `fs_ignore` = 0, an early edge discards the partial word, which is never presented. It sets `sync_err` to 1 and starts a new word aligned to the early edge, with the channel of that edge.
- R9: `sync_err` stays 1 until `err_clr` = 1 is sampled at a rising `bclk` edge, which clears it. If an early edge and `err_clr` occur in the same cycle, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock from the external master |
| rst_n | input | 1 | Active-low asynchronous reset |
| ws | input | 1 | Word select / frame sync from the master |
| sd | input | 1 | Serial data, MSB first |
| fs_ignore | input | 1 | 1: ignore early frame edges; 0: abort and resync |
| delay | input | 2 | Data delay in bit clocks after the frame edge (0 to 2) |
| err_clr | input | 1 | Clears the sticky sync-error flag when high |
| word_out | output | 16 | Last completed word |
| chan_out | output | 1 | Channel of the last completed word (0 left, 1 right) |
| valid | output | 1 | One-cycle strobe for a completed word |
| sync_err | output | 1 | Sticky flag set by an aborting early edge |

## Verification
The hardest case to reach from the ports is an early edge that lands in the middle of a word. The bench reaches it by building a per-cycle pattern for word select and serial data. A left half is cut short after 8 bit clocks, and the right word's bits start at the early edge plus the delay. In abort mode the scoreboard expects only the right word, and the truncated left word must never appear. In ignore mode the same edge pattern is used, but the left word is carried through all 16 bits and is expected intact with no error.

// File: rtl/i2s_fsync_rx.sv
module i2s_fsync_rx #(
  parameter int W = 16
) (
  input  logic         bclk,
  input  logic         rst_n,
  input  logic         ws,
  input  logic         sd,
  input  logic         fs_ignore,
  input  logic [1:0]   delay,
  input  logic         err_clr,
  output logic [W-1:0] word_out,
  output logic         chan_out,
  output logic         valid,
  output logic         sync_err
);
  localparam int BW = $clog2(W);
  localparam int CW = $clog2(W) + 1;

  logic          ws_q, seen, armed, pend, pchan, shifting, cur_chan;
  logic [CW-1:0] since;
  logic [1:0]    st;
  logic [BW-1:0] bcnt;
  logic [W-1:0]  sh;

  wire [1:0] dly       = (delay == 2'd3) ? 2'd2 : delay;
  wire       fedge     = seen && (ws != ws_q);
  wire       early     = fedge && armed && (since < CW'(W));
  wire       abort     = early && !fs_ignore;
  wire       accept    = fedge && !(early && fs_ignore);
  wire       start_now = (accept && dly == 2'd0) || (!accept && pend && st == 2'd0);
  wire       start_ch  = accept ? ws : pchan;
  wire       last      = shifting && !abort && (bcnt == BW'(W-1));

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      ws_q <= 1'b0; seen <= 1'b0; armed <= 1'b0; since <= '0;
      pend <= 1'b0; st <= '0; pchan <= 1'b0;
      shifting <= 1'b0; bcnt <= '0; sh <= '0; cur_chan <= 1'b0;
      word_out <= '0; chan_out <= 1'b0; valid <= 1'b0; sync_err <= 1'b0;
    end else begin
      ws_q <= ws;
      seen <= 1'b1;

      if (accept) begin
        armed <= 1'b1;
        since <= CW'(1);
      end else if (since < CW'(W)) begin
        since <= since + CW'(1);
      end

      if (accept) begin
        pend  <= (dly != 2'd0);
        st    <= dly - 2'd1;
        pchan <= ws;
      end else if (pend) begin
        if (st == 2'd0) pend <= 1'b0;
        else            st   <= st - 2'd1;
      end

      if (start_now) begin
        shifting <= 1'b1;
        bcnt     <= BW'(1);
        sh       <= {{(W-1){1'b0}}, sd};
        cur_chan <= start_ch;
      end else if (abort) begin
        shifting <= 1'b0;
      end else if (shifting) begin
        sh   <= {sh[W-2:0], sd};
        bcnt <= bcnt + BW'(1);
        if (bcnt == BW'(W-1)) shifting <= 1'b0;
      end

      valid <= last;
      if (last) begin
        word_out <= {sh[W-2:0], sd};
        chan_out <= cur_chan;
      end

      if (abort)        sync_err <= 1'b1;
      else if (err_clr) sync_err <= 1'b0;
    end
  end

  a_r5_single_strobe: assert property (@(posedge bclk) disable iff (!rst_n)
    valid |=> !valid);
  a_r7_ignore_no_error: assert property (@(posedge bclk) disable iff (!rst_n)
    fs_ignore |=> !$rose(sync_err));
  a_r8_abort_sets_flag: assert property (@(posedge bclk) disable iff (!rst_n)
    (early && !fs_ignore) |=> sync_err);
  a_r8_abort_no_strobe: assert property (@(posedge bclk) disable iff (!rst_n)
    (early && !fs_ignore) |=> !valid);
  a_r9_sticky: assert property (@(posedge bclk) disable iff (!rst_n)
    (sync_err && !err_clr) |=> sync_err);
  a_r9_clear: assert property (@(posedge bclk) disable iff (!rst_n)
    (err_clr && !fedge) |=> !sync_err);
  a_r2_first_edge_accepted: assert property (@(posedge bclk) disable iff (!rst_n)
    (fedge && !armed) |=> armed);
endmodule

// File: tb/i2s_fsync_rx_bench.sv
module i2s_fsync_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic bclk = 1'b0, rst_n = 1'b0, ws = 1'b1, sd = 1'b0;
  logic fs_ignore = 1'b0, err_clr = 1'b0;
  logic [1:0] delay = 2'd1;
  logic [W-1:0] word_out;
  logic chan_out, valid, sync_err;

  i2s_fsync_rx #(.W(W)) u_i2s_fsync_rx (
    .bclk(bclk), .rst_n(rst_n), .ws(ws), .sd(sd), .fs_ignore(fs_ignore),
    .delay(delay), .err_clr(err_clr), .word_out(word_out), .chan_out(chan_out),
    .valid(valid), .sync_err(sync_err));

  always #(CLK_PERIOD/2) bclk = ~bclk;

  int checks = 0, fails = 0;
  logic [W:0] expq[$];
  logic ws_a[256];
  logic sd_a[256];
  logic prev_valid = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge bclk) begin
    if (rst_n) begin
      if (valid) begin
        if (expq.size() == 0)
          chk(1'b0, "R5", "unexpected word strobe", {15'd0, chan_out, word_out}, 32'd0);
        else begin
          logic [W:0] e;
          e = expq.pop_front();
          chk({chan_out, word_out} == e, "R3/R4/R5", "word and channel",
              {15'd0, chan_out, word_out}, {15'd0, e});
        end
      end
      if (prev_valid && valid)
        chk(1'b0, "R5", "strobe longer than one cycle", 32'd1, 32'd0);
      prev_valid = valid;
    end
  end

  task automatic play(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge bclk);
      ws = ws_a[k];
      sd = sd_a[k];
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge bclk);
      sd = ~sd;
    end
  endtask

  function automatic logic [W-1:0] gen(input int i, input logic [W-1:0] seed);
    return (16'hA5C3 ^ W'(i * 16'h1F07)) + seed;
  endfunction

  task automatic stream(input int d, input int n, input logic [W-1:0] seed);
    int len;
    len = 16*n + d + 4;
    delay = 2'(d);
    for (int i = 0; i < n; i++) expq.push_back({1'(i % 2), gen(i, seed)});
    for (int k = 0; k < len; k++) begin
      int j;
      ws_a[k] = (k < 16*n) ? 1'((k/16) % 2) : 1'((n-1) % 2);
      j = k - d;
      if (j >= 0 && j/16 < n) begin
        logic [W-1:0] w;
        w = gen(j/16, seed);
        sd_a[k] = w[15 - (j % 16)];
      end else sd_a[k] = 1'b0;
    end
    idle(3);
    play(len);
  endtask

  task automatic early_case(input bit ign, input logic [W-1:0] lw, input logic [W-1:0] rw);
    delay = 2'd1;
    fs_ignore = ign;
    if (ign) expq.push_back({1'b0, lw});
    else     expq.push_back({1'b1, rw});
    for (int k = 0; k < 30; k++) begin
      ws_a[k] = (k >= 8);
      if (ign) sd_a[k] = (k >= 1 && k <= 16) ? lw[16 - k] : 1'b0;
      else if (k >= 1 && k <= 7) sd_a[k] = lw[16 - k];
      else sd_a[k] = (k >= 9 && k <= 24) ? rw[24 - k] : 1'b0;
    end
    idle(3);
    play(30);
  endtask

  initial begin
    repeat (100000) @(posedge bclk);
    chk(1'b0, "ALL", "watchdog expired", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge bclk);
    chk(valid == 1'b0 && word_out == '0 && sync_err == 1'b0, "R1", "reset state",
        {14'd0, valid, sync_err, word_out}, 32'd0);
    rst_n = 1'b1;

    // R2: held level starts no words
    idle(40);
    chk(expq.size() == 0, "R2", "no word from held ws", 32'(expq.size()), 32'd0);

    // R3/R4: the three delays, alternating channels
    stream(1, 4, 16'h0000);
    stream(0, 4, 16'h3C5A);
    stream(2, 4, 16'h9001);
    stream(1, 2, 16'hFFFF);
    chk(sync_err == 1'b0, "R6", "regular framing raises no error", {31'd0, sync_err}, 32'd0);

    // R7: early edge ignored
    early_case(1'b1, 16'hBEEF, 16'h1234);
    chk(sync_err == 1'b0, "R7", "ignored edge leaves flag clear", {31'd0, sync_err}, 32'd0);
    chk(expq.size() == 0, "R7", "left word completed", 32'(expq.size()), 32'd0);

    // R8: early edge aborts
    early_case(1'b0, 16'hDEAD, 16'hC0DE);
    chk(sync_err == 1'b1, "R8", "abort sets flag", {31'd0, sync_err}, 32'd1);
    chk(expq.size() == 0, "R8", "only realigned word produced", 32'(expq.size()), 32'd0);

    // R9: sticky through clean traffic, then cleared
    stream(1, 2, 16'h7777);
    chk(sync_err == 1'b1, "R9", "flag sticky", {31'd0, sync_err}, 32'd1);
    @(negedge bclk); err_clr = 1'b1;
    @(negedge bclk); err_clr = 1'b0;
    chk(sync_err == 1'b0, "R9", "flag cleared", {31'd0, sync_err}, 32'd0);

    stream(2, 2, 16'h0F0F);
    idle(5);
    chk(expq.size() == 0, "R5", "every expected word strobed", 32'(expq.size()), 32'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule